// File: doc/BRIEF.md
# Carrier Frequency Word Register with Atomic Commit

This block stores the 24-bit tuning word of a fractional-N frequency synthesizer behind a byte-wide register bus. The synthesizer's output frequency is the word times a fixed step, the step being the reference crystal frequency divided by 2^19. The step does not change across the tuning range. Software writes the word one byte at a time.

A tuning change must never reach the synthesizer half-written. The two upper bytes are therefore held in staging registers, and a write to them has no effect on the synthesizer. A write to the low byte copies the staged upper bytes and the new low byte into the active word in a single clock. On the same edge the block raises a one-cycle retune pulse, which asks the loop to relock. A two-bit band select input sets the oscillator multiplication factor that the synthesizer applies.

Top module: `carrier_freq_reg`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, the active word equals the default value 0x6C8000. Reads of the upper two byte addresses return 0x6C and 0x80, and retune is low.
- R2: A write to address 0x07 or 0x08 changes neither the active word nor retune.
- R3: A write to address 0x09 loads the active word in one clock. Bits 23:16 take the byte staged at 0x07, bits 15:8 take the byte staged at 0x08, and bits 7:0 take the written byte. The new word is visible on the cycle after the write strobe.
- R4: Retune is high for exactly the one cycle after each write to 0x09. Two writes to 0x09 on consecutive cycles give two consecutive high cycles, and retune is low at all other times.
- R5: A read strobe makes read data valid on the next cycle. A read of 0x07 or 0x08 returns the staged byte, and a read of 0x09 returns bits 7:0 of the active word.
- R6: Reads of any address outside 0x07 to 0x09 return 0x00. Writes to such an address change neither the active word, the staged bytes nor retune.
- R7: The oscillator multiplier output depends only on band select. Band select 0 (the 915 MHz band) gives 2, 1 (434 MHz) gives 4, 2 (315 MHz) gives 6, and the reserved value 3 gives 2.
- R8: A commit leaves the staged bytes unchanged, so a later write to 0x09 alone reuses the previously staged upper bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Byte address for the read and write strobes |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe, one cycle per read |
| bandSel | input | 2 | Band select: 0 = 915 MHz, 1 = 434 MHz, 2 = 315 MHz, 3 = reserved |
| rdData | output | 8 | Read data, registered; valid the cycle after rdEn |
| activeWord | output | 24 | Tuning word presented to the synthesizer |
| retune | output | 1 | One-cycle pulse that requests a relock |
| vcoMult | output | 3 | Oscillator multiplication factor |

## Verification
A corrupted staging byte stays hidden until the next read of that address, or until the next low-byte write, which moves it onto the active word one cycle after the strobe. A wrong commit decode shows up on the cycle right after the write. It appears either as a retune pulse and a word change after an upper-byte write, or as a missing pulse after a low-byte write. The bench therefore samples every output on that cycle after each write, reads the staged bytes back between writes, and repeats low-byte commits on their own to catch staging that is lost or cleared.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

  localparam int LANE_W = 4;

  // Decoded bus cycle, passed from control to datapath
  typedef struct packed {
    logic              stage;   // write to an upper (staged) byte
    logic              commit;  // write to the low byte
    logic              rdAny;   // any read strobe
    logic              rdHit;   // read strobe inside the word window
    logic [LANE_W-1:0] lane;    // byte index within the window, 0 = top byte
  } cfr_strobe_t;

  typedef enum logic [1:0] {
    BAND_HIGH = 2'd0,  // 915 MHz band
    BAND_MID  = 2'd1,  // 434 MHz band
    BAND_LOW  = 2'd2,  // 315 MHz band
    BAND_RSVD = 2'd3
  } band_e;

  function automatic logic [2:0] vcoFactor(input logic [1:0] sel);
    case (band_e'(sel))
      BAND_MID: vcoFactor = 3'd4;
      BAND_LOW: vcoFactor = 3'd6;
      default:  vcoFactor = 3'd2;
    endcase
  endfunction

endpackage

// File: rtl/cfr_control.sv
module cfr_control
  import cfr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int BASE_ADDR  = 7,
  parameter int WORD_BYTES = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output cfr_strobe_t       strb
);

  localparam logic [ADDR_W-1:0] FIRST = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(BASE_ADDR + WORD_BYTES - 1);
  localparam logic [ADDR_W-1:0] LO_OFFSET = ADDR_W'(WORD_BYTES - 1);

  logic              inWindow;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    inWindow = (addr >= FIRST) && (addr <= LAST);
    offset   = addr - FIRST;

    strb.stage  = wrEn && inWindow && (offset != LO_OFFSET);
    strb.commit = wrEn && inWindow && (offset == LO_OFFSET);
    strb.rdAny  = rdEn;
    strb.rdHit  = rdEn && inWindow;
    strb.lane   = LANE_W'(offset);
  end

endmodule

// File: rtl/cfr_datapath.sv
module cfr_datapath
  import cfr_pkg::*;
#(
  parameter int                      WORD_BYTES = 3,
  parameter logic [8*WORD_BYTES-1:0] RESET_WORD = 24'h6C8000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cfr_strobe_t             strb,
  input  logic [7:0]              wrData,
  input  logic [1:0]              bandSel,
  output logic [7:0]              rdData,
  output logic [8*WORD_BYTES-1:0] activeWord,
  output logic                    retune,
  output logic [2:0]              vcoMult
);

  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int UPPER  = WORD_BYTES - 1;

  logic [7:0]        stagedQ [UPPER];
  logic [WORD_W-1:0] commitWord;
  logic [WORD_W-1:0] activeQ;
  logic              retuneQ;
  logic [7:0]        rdQ;
  logic [7:0]        rdByte;

  // One staging register per upper byte; lane 0 is the most significant
  for (genvar i = 0; i < UPPER; i++) begin : g_stage
    localparam int LSB = (WORD_BYTES - 1 - i) * 8;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        stagedQ[i] <= RESET_WORD[LSB +: 8];
      else if (strb.stage && (strb.lane == LANE_W'(i)))
        stagedQ[i] <= wrData;
    end

    assign commitWord[LSB +: 8] = stagedQ[i];
  end

  assign commitWord[7:0] = wrData;

  // Active word and retune pulse move together on a commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= RESET_WORD;
      retuneQ <= 1'b0;
    end else begin
      retuneQ <= strb.commit;
      if (strb.commit)
        activeQ <= commitWord;
    end
  end

  // Read mux: staged bytes for upper lanes, active low byte for the last lane
  always_comb begin
    rdByte = activeQ[7:0];
    for (int k = 0; k < UPPER; k++)
      if (strb.lane == LANE_W'(k))
        rdByte = stagedQ[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdQ <= 8'h00;
    else if (strb.rdAny)
      rdQ <= strb.rdHit ? rdByte : 8'h00;
  end

  assign rdData     = rdQ;
  assign activeWord = activeQ;
  assign retune     = retuneQ;
  assign vcoMult    = vcoFactor(bandSel);

endmodule

// File: rtl/carrier_freq_reg.sv
module carrier_freq_reg
  import cfr_pkg::*;
#(
  parameter int                      ADDR_W     = 8,
  parameter int                      BASE_ADDR  = 7,
  parameter int                      WORD_BYTES = 3,
  parameter logic [8*WORD_BYTES-1:0] RESET_WORD = 24'h6C8000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              wrData,
  input  logic                    wrEn,
  input  logic                    rdEn,
  input  logic [1:0]              bandSel,
  output logic [7:0]              rdData,
  output logic [8*WORD_BYTES-1:0] activeWord,
  output logic                    retune,
  output logic [2:0]              vcoMult
);

  cfr_strobe_t strb;

  cfr_control #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .WORD_BYTES(WORD_BYTES)
  ) u_ctrl (
    .addr(addr),
    .wrEn(wrEn),
    .rdEn(rdEn),
    .strb(strb)
  );

  cfr_datapath #(
    .WORD_BYTES(WORD_BYTES),
    .RESET_WORD(RESET_WORD)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .bandSel   (bandSel),
    .rdData    (rdData),
    .activeWord(activeWord),
    .retune    (retune),
    .vcoMult   (vcoMult)
  );

endmodule

// File: rtl/cfr_checker.sv
module cfr_checker #(
  parameter int ADDR_W     = 8,
  parameter int BASE_ADDR  = 7,
  parameter int WORD_BYTES = 3
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [ADDR_W-1:0]       addr,
  input logic [7:0]              wrData,
  input logic                    wrEn,
  input logic [1:0]              bandSel,
  input logic [8*WORD_BYTES-1:0] activeWord,
  input logic                    retune,
  input logic [2:0]              vcoMult
);

  localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(BASE_ADDR + WORD_BYTES - 1);

  logic loWrite;
  assign loWrite = wrEn && (addr == LO_ADDR);

  // R4
  retune_after_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    loWrite |=> retune);

  // R4
  retune_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loWrite |=> !retune);

  // R2
  word_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loWrite |=> $stable(activeWord));

  // R3
  low_byte_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    loWrite |=> (activeWord[7:0] == $past(wrData)));

  // R7
  mult_mid_band_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bandSel == 2'd1) |-> (vcoMult == 3'd4));

  // R7
  mult_low_band_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bandSel == 2'd2) |-> (vcoMult == 3'd6));

  // R7
  mult_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vcoMult == 3'd2) || (vcoMult == 3'd4) || (vcoMult == 3'd6));

endmodule

bind carrier_freq_reg cfr_checker #(
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR),
  .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .addr      (addr),
  .wrData    (wrData),
  .wrEn      (wrEn),
  .bandSel   (bandSel),
  .activeWord(activeWord),
  .retune    (retune),
  .vcoMult   (vcoMult)
);

// File: tb/tb_carrier_freq_reg.sv
`timescale 1ns/1ps
module tb_carrier_freq_reg;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [7:0]  wrData = 8'h00;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  bandSel = 2'd0;
  logic [7:0]  rdData;
  logic [23:0] activeWord;
  logic        retune;
  logic [2:0]  vcoMult;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  carrier_freq_reg dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .bandSel(bandSel), .rdData(rdData), .activeWord(activeWord),
    .retune(retune), .vcoMult(vcoMult)
  );

  typedef struct packed {
    logic        isWr;
    logic [7:0]  a;
    logic [7:0]  d;
    logic [23:0] expWord;
    logic        expRetune;
    logic        chkRd;
    logic [7:0]  expRd;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h07, 8'h00, 24'h6C8000, 1'b0, 1'b1, 8'h6C},  // R1 R5
    '{1'b0, 8'h08, 8'h00, 24'h6C8000, 1'b0, 1'b1, 8'h80},  // R1 R5
    '{1'b0, 8'h09, 8'h00, 24'h6C8000, 1'b0, 1'b1, 8'h00},  // R5
    '{1'b1, 8'h07, 8'hAB, 24'h6C8000, 1'b0, 1'b0, 8'h00},  // R2
    '{1'b1, 8'h08, 8'hCD, 24'h6C8000, 1'b0, 1'b0, 8'h00},  // R2
    '{1'b0, 8'h07, 8'h00, 24'h6C8000, 1'b0, 1'b1, 8'hAB},  // R5
    '{1'b0, 8'h09, 8'h00, 24'h6C8000, 1'b0, 1'b1, 8'h00},  // R2
    '{1'b1, 8'h09, 8'hEF, 24'hABCDEF, 1'b1, 1'b0, 8'h00},  // R3 R4
    '{1'b0, 8'h09, 8'h00, 24'hABCDEF, 1'b0, 1'b1, 8'hEF},  // R4 R5
    '{1'b1, 8'h09, 8'h12, 24'hABCD12, 1'b1, 1'b0, 8'h00},  // R8
    '{1'b1, 8'h0A, 8'h55, 24'hABCD12, 1'b0, 1'b0, 8'h00},  // R6
    '{1'b0, 8'h0A, 8'h00, 24'hABCD12, 1'b0, 1'b1, 8'h00},  // R6
    '{1'b1, 8'h06, 8'h77, 24'hABCD12, 1'b0, 1'b0, 8'h00},  // R6
    '{1'b0, 8'h06, 8'h00, 24'hABCD12, 1'b0, 1'b1, 8'h00},  // R6
    '{1'b1, 8'h08, 8'h01, 24'hABCD12, 1'b0, 1'b0, 8'h00},  // R2
    '{1'b0, 8'h08, 8'h00, 24'hABCD12, 1'b0, 1'b1, 8'h01},  // R5 R6
    '{1'b1, 8'h09, 8'h02, 24'hAB0102, 1'b1, 1'b0, 8'h00}   // R3 R8
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Drive one bus cycle at the falling edge, sample outputs one edge later
  task automatic busOp(input bit isWr, input logic [7:0] a, input logic [7:0] d);
    addr   = a;
    wrData = d;
    wrEn   = isWr;
    rdEn   = !isWr;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    rdEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: outputs during reset
    repeat (2) @(negedge clk);
    check(activeWord == 24'h6C8000, "R1 word in reset", 32'(activeWord), 32'h6C8000);
    check(retune == 1'b0, "R1 retune in reset", 32'(retune), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(activeWord == 24'h6C8000, "R1 word after reset", 32'(activeWord), 32'h6C8000);
    check(retune == 1'b0, "R1 retune after reset", 32'(retune), 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      busOp(VEC[i].isWr, VEC[i].a, VEC[i].d);
      check(activeWord == VEC[i].expWord, $sformatf("R2/R3 word vec %0d", i),
            32'(activeWord), 32'(VEC[i].expWord));
      check(retune == VEC[i].expRetune, $sformatf("R4 retune vec %0d", i),
            32'(retune), 32'(VEC[i].expRetune));
      if (VEC[i].chkRd)
        check(rdData == VEC[i].expRd, $sformatf("R5/R6 rdData vec %0d", i),
              32'(rdData), 32'(VEC[i].expRd));
      @(negedge clk);
      check(retune == 1'b0, $sformatf("R4 pulse width vec %0d", i), 32'(retune), 0);
    end

    // R4: back-to-back commits give two high cycles, then low
    addr = 8'h09; wrData = 8'h33; wrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    check(retune == 1'b1, "R4 first of pair", 32'(retune), 1);
    wrData = 8'h44;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
    check(retune == 1'b1, "R4 second of pair", 32'(retune), 1);
    check(activeWord == 24'hAB0144, "R8 pair word", 32'(activeWord), 32'hAB0144);
    @(negedge clk);
    check(retune == 1'b0, "R4 after pair", 32'(retune), 0);

    // R7: multiplier decode for every band code
    for (int b = 0; b < 4; b++) begin
      logic [2:0] exp;
      bandSel = 2'(b);
      exp = (b == 1) ? 3'd4 : (b == 2) ? 3'd6 : 3'd2;
      #1;
      check(vcoMult == exp, $sformatf("R7 band %0d", b), 32'(vcoMult), 32'(exp));
    end
    bandSel = 2'd0;

    // R1: reset mid-run restores defaults
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(activeWord == 24'h6C8000, "R1 re-reset word", 32'(activeWord), 32'h6C8000);
    rstN = 1'b1;
    @(negedge clk);
    busOp(1'b0, 8'h08, 8'h00);
    check(rdData == 8'h80, "R1 re-reset staged mid", 32'(rdData), 32'h80);
    busOp(1'b1, 8'h09, 8'h5A);
    check(activeWord == 24'h6C805A, "R1 R3 commit of default upper", 32'(activeWord),
          32'h6C805A);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule